// File: doc/BRIEF.md
# Serial-Bus Digital Potentiometer Controller

This block is an I2C slave that controls a 64-step digital potentiometer. It runs on a fast system clock and oversamples SCL and SDA. It detects START, repeated START and STOP, and compares the first byte of each transfer with its own 7-bit address. That address is built from two three-state strap pins, which are sampled once after reset. The result of the block is the 6-bit wiper code.

After its address, a write transfer carries an instruction byte. The three upper bits of that byte choose one operation:

- load the wiper
- load a nonvolatile shadow copy of the wiper
- set or clear a software write lock
- copy the wiper into the shadow copy
- copy the shadow copy back into the wiper
- select a fixed tolerance byte for readback

The instruction persists for the rest of the transfer, so data bytes can be streamed into the same target until STOP. A read is done in two parts. A write of address and instruction selects the target. Then a repeated START and the address with the read bit set return the selected value, one byte per master acknowledge.

Top module: `digipot_i2c`

## Requirements
- R1: After reset the wiper is 32 (midscale), the shadow copy is 32, the lock is clear and SDA is released (sdaOe low).
- R2: The slave address is {ADDR_PREFIX, code(strapB), code(strapA)}, where a strap value of 00 is low (code 0), 01 is high (code 1) and 1x is floating (code 2). A byte after START whose upper 7 bits differ from this address is not acknowledged, and SDA stays released until the next START.
- R3: A matching address byte, an accepted instruction byte and an accepted data byte are acknowledged by holding SDA low for the whole ninth SCL clock of that byte. Bit 0 of the address byte is the direction: 1 is read, 0 is write.
- R4: Instruction bits 7:5 are the command: 000 wiper, 001 shadow, 010 lock, 100 copy wiper to shadow, 101 copy shadow to wiper, 110 tolerance. Commands 011 and 111, and any instruction with nonzero bits 4:0, are not acknowledged.
- R5: A data byte under command 000 loads bits 5:0 into the wiper. Bits 7:6 are ignored.
- R6: Under command 000 every further data byte is acknowledged and reloads the wiper, until STOP.
- R7: Command 001 loads bits 5:0 of the data byte into the shadow copy. Commands 100 and 101 take effect on the instruction byte alone, and a data byte sent after them is not acknowledged.
- R8: Command 010 sets the lock when data bit 0 is 1 and clears it when that bit is 0. While the lock is set, commands 000, 001, 100 and 101 are acknowledged but change neither the wiper nor the shadow copy.
- R9: A read returns {2'b00, shadow} after command 001, the constant TOL_BYTE after command 110, and {2'b00, wiper} otherwise. The byte is sent MSB first, and SDA changes only after a falling SCL edge.
- R10: While the master acknowledges read bytes, the same register is sent again. A master NACK ends the read and releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| strapA | input | 2 | Three-state strap for address code bits 1:0 (00 low, 01 high, 1x floating) |
| strapB | input | 2 | Three-state strap for address code bits 3:2 (same encoding) |
| wiper | output | WIPER_W | Current wiper code |

## Verification
Every bus edge passes through a two-flop synchronizer and an edge register before the controller reacts, so the controller acts on an edge about three system clocks after it appears. The acknowledge and any register update follow one clock after that, so they are settled within four clocks of the falling SCL edge that ends bit 8. The bench holds each bus phase for ten system clocks. It samples SDA in the middle of the SCL-high phase and reads the wiper only after the ninth clock of the byte has completed. Every sample therefore falls well after the result is due and well before the next bus edge.

// File: rtl/digipot_pkg.sv
package digipot_pkg;

  localparam logic [2:0] CMD_WIPER   = 3'b000;
  localparam logic [2:0] CMD_SHADOW  = 3'b001;
  localparam logic [2:0] CMD_LOCK    = 3'b010;
  localparam logic [2:0] CMD_SAVE    = 3'b100;
  localparam logic [2:0] CMD_RECALL  = 3'b101;
  localparam logic [2:0] CMD_TOL     = 3'b110;

  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic       wrWiper;
    logic       wrShadow;
    logic       wrLock;
    logic       save;
    logic       recall;
    logic [7:0] data;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_DATA, ST_READ, ST_IGNORE
  } state_e;

endpackage

// File: rtl/digipot_regs.sv
module digipot_regs
  import digipot_pkg::*;
#(
  parameter int         WIPER_W  = 6,
  parameter int         MID_CODE = 32,
  parameter logic [7:0] TOL_BYTE = 8'hA7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            stb,
  input  logic [2:0]         cmdSel,
  output logic [WIPER_W-1:0] wiper,
  output logic [7:0]         rdByte
);

  localparam logic [WIPER_W-1:0] MID = WIPER_W'(MID_CODE);

  logic [WIPER_W-1:0] wiperQ;
  logic [WIPER_W-1:0] shadowQ;
  logic               lockQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiperQ  <= MID;
      shadowQ <= MID;
      lockQ   <= 1'b0;
    end else begin
      if (stb.wrLock) lockQ <= stb.data[0];
      if (!lockQ) begin
        if (stb.wrWiper)  wiperQ  <= stb.data[WIPER_W-1:0];
        if (stb.recall)   wiperQ  <= shadowQ;
        if (stb.wrShadow) shadowQ <= stb.data[WIPER_W-1:0];
        if (stb.save)     shadowQ <= wiperQ;
      end
    end
  end

  always_comb begin
    case (cmdSel)
      CMD_SHADOW: rdByte = 8'(shadowQ);
      CMD_TOL:    rdByte = TOL_BYTE;
      default:    rdByte = 8'(wiperQ);
    endcase
  end

  assign wiper = wiperQ;

  // R8
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockQ |=> ($stable(wiperQ) && $stable(shadowQ)));

  // R5
  wiper_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrWiper && !lockQ) |=> (wiperQ == $past(stb.data[WIPER_W-1:0])));

  // R7
  save_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.save && !lockQ) |=> (shadowQ == $past(wiperQ)));

  // R7
  recall_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.recall && !lockQ) |=> (wiperQ == $past(shadowQ)));

endmodule

// File: rtl/digipot_i2c_ctrl.sv
module digipot_i2c_ctrl
  import digipot_pkg::*;
#(
  parameter logic [2:0] ADDR_PREFIX = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [1:0] strapA,
  input  logic [1:0] strapB,
  input  logic [7:0] rdByte,
  output strobe_t    stb,
  output logic [2:0] cmdSel,
  output logic       sdaOe
);

  localparam int CNT_W = 4;

  function automatic logic [1:0] tritCode(input logic [1:0] pin);
    return pin[1] ? 2'd2 : {1'b0, pin[0]};
  endfunction

  function automatic logic instrOk(input logic [7:0] b);
    return (b[4:0] == 5'd0) && (b[6:5] != 2'b11);
  endfunction

  logic [2:0]       sclS, sdaS;
  logic             sclRise, sclFall, startDet, stopDet;
  state_e           state;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0]       rxReg, txReg;
  logic [6:0]       myAddr;
  logic             strapDone, rwQ, masterAck;
  logic [2:0]       cmdQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclS <= '1;
      sdaS <= '1;
    end else begin
      sclS <= {sclS[1:0], scl};
      sdaS <= {sdaS[1:0], sdaIn};
    end
  end

  assign sclRise  =  sclS[1] & ~sclS[2];
  assign sclFall  = ~sclS[1] &  sclS[2];
  assign startDet =  sclS[1] &  sclS[2] &  sdaS[2] & ~sdaS[1];
  assign stopDet  =  sclS[1] &  sclS[2] & ~sdaS[2] &  sdaS[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rxReg     <= '0;
      txReg     <= '0;
      sdaOe     <= 1'b0;
      cmdQ      <= CMD_WIPER;
      rwQ       <= 1'b0;
      masterAck <= 1'b0;
      myAddr    <= '0;
      strapDone <= 1'b0;
      stb       <= '0;
    end else begin
      stb <= '0;
      if (!strapDone) begin
        myAddr    <= {ADDR_PREFIX, tritCode(strapB), tritCode(strapA)};
        strapDone <= 1'b1;
      end
      if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopDet) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else if (state != ST_IDLE && state != ST_IGNORE) begin
        if (sclRise) begin
          if (bitCnt < CNT_W'(8)) rxReg <= {rxReg[6:0], sdaS[1]};
          else                    masterAck <= ~sdaS[1];
          bitCnt <= bitCnt + CNT_W'(1);
        end else if (sclFall) begin
          if (bitCnt == CNT_W'(8)) begin
            case (state)
              ST_ADDR:
                if (rxReg[7:1] == myAddr) begin
                  sdaOe <= 1'b1;
                  rwQ   <= rxReg[0];
                end else state <= ST_IGNORE;
              ST_INSTR:
                if (instrOk(rxReg)) begin
                  sdaOe      <= 1'b1;
                  cmdQ       <= rxReg[7:5];
                  stb.save   <= (rxReg[7:5] == CMD_SAVE);
                  stb.recall <= (rxReg[7:5] == CMD_RECALL);
                end else state <= ST_IGNORE;
              ST_DATA:
                if (cmdQ == CMD_WIPER || cmdQ == CMD_SHADOW || cmdQ == CMD_LOCK) begin
                  sdaOe        <= 1'b1;
                  stb.data     <= rxReg;
                  stb.wrWiper  <= (cmdQ == CMD_WIPER);
                  stb.wrShadow <= (cmdQ == CMD_SHADOW);
                  stb.wrLock   <= (cmdQ == CMD_LOCK);
                end else state <= ST_IGNORE;
              default: sdaOe <= 1'b0;  // read: free the line for the master ack
            endcase
          end else if (bitCnt == CNT_W'(9)) begin
            bitCnt <= '0;
            case (state)
              ST_ADDR:
                if (rwQ) begin
                  state <= ST_READ;
                  sdaOe <= ~rdByte[7];
                  txReg <= {rdByte[6:0], 1'b0};
                end else begin
                  state <= ST_INSTR;
                  sdaOe <= 1'b0;
                end
              ST_INSTR: begin
                state <= ST_DATA;
                sdaOe <= 1'b0;
              end
              ST_READ:
                if (masterAck) begin
                  sdaOe <= ~rdByte[7];
                  txReg <= {rdByte[6:0], 1'b0};
                end else begin
                  state <= ST_IGNORE;
                  sdaOe <= 1'b0;
                end
              default: sdaOe <= 1'b0;
            endcase
          end else if (state == ST_READ && bitCnt != '0) begin
            sdaOe <= ~txReg[7];
            txReg <= {txReg[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign cmdSel = cmdQ;

  // R2
  quiet_when_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE || state == ST_IDLE) |-> !sdaOe);

  // R9
  sda_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdaOe) |-> $past(sclFall || startDet || stopDet));

  // R3
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdaOe && state != ST_READ) |-> (bitCnt == CNT_W'(8) || bitCnt == CNT_W'(9)));

endmodule

// File: rtl/digipot_i2c.sv
module digipot_i2c
  import digipot_pkg::*;
#(
  parameter logic [2:0] ADDR_PREFIX = 3'b010,
  parameter int         WIPER_W     = 6,
  parameter int         MID_CODE    = 32,
  parameter logic [7:0] TOL_BYTE    = 8'hA7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl,
  input  logic               sdaIn,
  output logic               sdaOe,
  input  logic [1:0]         strapA,
  input  logic [1:0]         strapB,
  output logic [WIPER_W-1:0] wiper
);

  strobe_t    stb;
  logic [2:0] cmdSel;
  logic [7:0] rdByte;

  digipot_i2c_ctrl #(.ADDR_PREFIX(ADDR_PREFIX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sdaIn(sdaIn),
    .strapA(strapA), .strapB(strapB), .rdByte(rdByte),
    .stb(stb), .cmdSel(cmdSel), .sdaOe(sdaOe)
  );

  digipot_regs #(.WIPER_W(WIPER_W), .MID_CODE(MID_CODE), .TOL_BYTE(TOL_BYTE)) u_regs (
    .clk(clk), .rst_n(rst_n), .stb(stb), .cmdSel(cmdSel),
    .wiper(wiper), .rdByte(rdByte)
  );

endmodule

// File: tb/tb_digipot_i2c.sv
`timescale 1ns/1ps
module tb_digipot_i2c;

  localparam int         Q       = 100;
  localparam logic [6:0] ADDR    = 7'h26;  // {010, code(01)=1, code(10)=2}
  localparam logic [7:0] TOL     = 8'hA7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaLine;
  logic [5:0] wiper;
  int nChecks = 0;
  int nFail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  digipot_i2c dut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapA(2'b10), .strapB(2'b01), .wiper(wiper)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; #Q; scl = 1'b1; #Q; sdaM = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic busStop();
    sdaM = 1'b0; #Q; scl = 1'b1; #Q; sdaM = 1'b1; #Q;
  endtask

  task automatic putBit(input logic b);
    sdaM = b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic getBit(output logic b);
    sdaM = 1'b1; #Q; scl = 1'b1; #Q; b = sdaLine; #Q; scl = 1'b0; #Q;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) getBit(v[i]);
    putBit(~giveAck);
  endtask

  task automatic writeOne(input logic [7:0] instr, input logic [7:0] d,
                          output logic aA, output logic aI, output logic aD);
    busStart();
    sendByte({ADDR, 1'b0}, aA);
    sendByte(instr, aI);
    sendByte(d, aD);
    busStop();
  endtask

  task automatic instrOnly(input logic [7:0] instr, output logic aI);
    logic aA;
    busStart();
    sendByte({ADDR, 1'b0}, aA);
    sendByte(instr, aI);
    busStop();
  endtask

  task automatic readOne(input logic [7:0] instr, output logic [7:0] v);
    logic a;
    busStart();
    sendByte({ADDR, 1'b0}, a);
    sendByte(instr, a);
    busStart();
    sendByte({ADDR, 1'b1}, a);
    recvByte(1'b0, v);
    busStop();
  endtask

  task automatic tResetState();
    check("R1 wiper at reset", int'(wiper), 32);
    check("R1 sda released at reset", int'(sdaOe), 0);
  endtask

  task automatic tWrongAddr();
    logic a;
    busStart();
    sendByte({7'h27, 1'b0}, a);
    check("R2 foreign address nack", int'(a), 0);
    sendByte(8'h00, a);
    check("R2 silent until next start", int'(a), 0);
    busStop();
    check("R2 wiper untouched", int'(wiper), 32);
  endtask

  task automatic tWriteWiper();
    logic aA, aI, aD;
    writeOne(8'h00, 8'hC5, aA, aI, aD);
    check("R3 address ack", int'(aA), 1);
    check("R3 instruction ack", int'(aI), 1);
    check("R3 data ack", int'(aD), 1);
    check("R5 upper bits dropped", int'(wiper), 5);
  endtask

  task automatic tStream();
    logic a;
    busStart();
    sendByte({ADDR, 1'b0}, a);
    sendByte(8'h00, a);
    sendByte(8'd10, a);
    check("R6 first streamed byte", int'(wiper), 10);
    sendByte(8'd20, a);
    check("R6 second streamed byte", int'(wiper), 20);
    sendByte(8'd63, a);
    check("R6 third streamed ack", int'(a), 1);
    busStop();
    check("R6 third streamed byte", int'(wiper), 63);
  endtask

  task automatic tBadInstr();
    logic a;
    instrOnly(8'h60, a);
    check("R4 command 011 nack", int'(a), 0);
    instrOnly(8'h01, a);
    check("R4 nonzero low bits nack", int'(a), 0);
    instrOnly(8'hE0, a);
    check("R4 command 111 nack", int'(a), 0);
  endtask

  task automatic tShadow();
    logic aA, aI, aD;
    logic [7:0] v;
    writeOne(8'h20, 8'd17, aA, aI, aD);
    check("R7 shadow write leaves wiper", int'(wiper), 63);
    readOne(8'h20, v);
    check("R9 shadow readback", int'(v), 17);
    instrOnly(8'h80, aI);
    readOne(8'h20, v);
    check("R7 save copies wiper", int'(v), 63);
    writeOne(8'h00, 8'd3, aA, aI, aD);
    instrOnly(8'hA0, aI);
    check("R7 recall restores wiper", int'(wiper), 63);
    writeOne(8'h80, 8'd1, aA, aI, aD);
    check("R7 data after save nack", int'(aD), 0);
  endtask

  task automatic tLock();
    logic aA, aI, aD;
    logic [7:0] v;
    writeOne(8'h40, 8'h01, aA, aI, aD);
    writeOne(8'h00, 8'd9, aA, aI, aD);
    check("R8 locked write acked", int'(aD), 1);
    check("R8 locked write no effect", int'(wiper), 63);
    writeOne(8'h20, 8'd2, aA, aI, aD);
    instrOnly(8'hA0, aI);
    check("R8 locked recall no effect", int'(wiper), 63);
    readOne(8'h20, v);
    check("R8 locked shadow write no effect", int'(v), 63);
    writeOne(8'h40, 8'hFE, aA, aI, aD);
    writeOne(8'h00, 8'd9, aA, aI, aD);
    check("R8 unlocked write works", int'(wiper), 9);
  endtask

  task automatic tReads();
    logic a;
    logic [7:0] v;
    readOne(8'hC0, v);
    check("R9 tolerance byte", int'(v), int'(TOL));
    busStart();
    sendByte({ADDR, 1'b0}, a);
    sendByte(8'h00, a);
    busStart();
    sendByte({ADDR, 1'b1}, a);
    recvByte(1'b1, v);
    check("R10 first wiper read", int'(v), 9);
    recvByte(1'b1, v);
    check("R10 repeated wiper read", int'(v), 9);
    recvByte(1'b0, v);
    check("R10 last wiper read", int'(v), 9);
    check("R10 sda released after nack", int'(sdaOe), 0);
    busStop();
  endtask

  initial begin
    #2;
    #50 rst_n = 1'b1;
    #100;
    tResetState();
    tWrongAddr();
    tWriteWiper();
    tStream();
    tBadInstr();
    tShadow();
    tLock();
    tReads();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule